// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer with Register Bus

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter in a small microcontroller. Software reaches it over a byte-wide register bus. It programs an input channel, starts a conversion and reads back the result. While a conversion runs, the block drives a trial code to an external resistor-ladder DAC and the chosen channel to an analog multiplexer. It samples a single comparator bit and settles the code one bit at a time, starting from the most significant bit.

A conversion starts when software clears the completion flag in the control register. The flag reads 0 while the conversion runs. When the last bit is settled, the flag returns to 1 and an interrupt request is raised. The interrupt request stays set until a dedicated clear pulse arrives. The 10-bit result is split across two byte registers: the upper eight bits are in one, and the two lowest bits are left-aligned in the other. One analog pin is shared with an external interrupt line, so the block masks that interrupt whenever the shared channel is selected.

Top module: `sar_adc_ctl`

## Requirements
- R1: After reset, the control register reads 0x10 (channel 0, completion flag 1), both result registers read 0x00, and irq_req is 0.
- R2: A write to address 0x32 stores bits 3:0 as the channel code. Reading 0x32 returns the channel code in bits 3:0 and the completion flag in bit 4. Bits 7:5 read 0, whatever was written to them.
- R3: A write to 0x32 with bit 4 = 0 starts a conversion, and the flag reads 0 from the next cycle. A write with bit 4 = 1 while idle starts nothing: the flag stays 1 and no interrupt follows.
- R4: The completion flag and irq_req become 1 exactly 11 clock edges after the edge that takes the start write. That is one setup cycle followed by ten trial cycles.
- R5: Trials go from bit 9 down to bit 0. In the first trial, dac_code is 0x200. A trial bit is kept only if cmp_in is 1, meaning the input is at or above the trial voltage. The final result is therefore the largest code that is not above the input.
- R6: At completion, result bits 9:2 appear at address 0x34. Result bits 1:0 appear in bits 7:6 of address 0x33, and bits 5:0 of 0x33 read 0.
- R7: While a conversion runs, both result registers keep the previous result.
- R8: A start write during a conversion restarts it from bit 9. Completion then comes 11 edges after the latest start write.
- R9: irq_req stays 1 until an irq_clr pulse. If the clear and a completion fall on the same edge, the request stays set.
- R10: While channel code 1010 is selected, ext_irq_out is 0. For every other code, ext_irq_out follows ext_irq_in.
- R11: The reserved channel codes 1100 to 1111 are stored and read back. While one of them is selected, chan_none is 1 and chan_en is all zero, and a conversion yields 0 whatever cmp_in reports.
- R12: Outside the trial cycles, dac_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 8 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 8 | Read address |
| bus_rdata | output | 8 | Read data, combinational from bus_raddr |
| irq_clr | input | 1 | Pulse that clears the interrupt request |
| cmp_in | input | 1 | Comparator: 1 when input is at or above trial voltage |
| dac_code | output | 10 | Trial code to the ladder DAC |
| chan_sel | output | 4 | Stored channel code to the analog multiplexer |
| chan_en | output | 12 | One-hot channel enable, all zero for reserved codes |
| chan_none | output | 1 | High when a reserved channel code is selected |
| irq_req | output | 1 | Conversion-complete interrupt request |
| ext_irq_in | input | 1 | External interrupt line sharing the analog pin |
| ext_irq_out | output | 1 | External interrupt after channel masking |

## Verification
Two events can land on the same clock edge: the completion that sets irq_req and the irq_clr pulse that clears it. The bench raises irq_clr in the cycle before the final trial edge and holds it through that edge. It then requires irq_req to read 1, and a separate clear afterwards must bring it to 0. A second overlap is a restart write that arrives mid-conversion. This is judged by the completion coming 11 edges after the second write rather than the first.

// File: rtl/sar_adc_pkg.sv
// Package: shared state encoding and register map for the SAR ADC sequencer.
// Assumes an 8-bit address space; offsets are fixed by software convention.
package sar_adc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_TRIAL = 2'd2
    } sar_state_e;

    localparam logic [7:0] ADDR_CTRL   = 8'h32;
    localparam logic [7:0] ADDR_RES_LO = 8'h33;
    localparam logic [7:0] ADDR_RES_HI = 8'h34;
    localparam int         FLAG_BIT    = 4;
endpackage

// File: rtl/sar_chan_decode.sv
// Channel decode: turns the stored channel code into a one-hot enable,
// flags reserved codes, forces the comparator low for them, and masks the
// external interrupt that shares the analog pin of channel GATE_CH.
// Assumes NUM_CH <= 2**CH_W.
module sar_chan_decode #(
    parameter int CH_W    = 4,
    parameter int NUM_CH  = 12,
    parameter int GATE_CH = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   chan,
    input  logic              cmp_raw,
    input  logic              ext_irq_in,
    output logic [NUM_CH-1:0] chan_en,
    output logic              chan_none,
    output logic              cmp_hit,
    output logic              ext_irq_out
);
    localparam logic [CH_W-1:0] GATE_CODE = CH_W'(GATE_CH);
    localparam logic [CH_W-1:0] LAST_CODE = CH_W'(NUM_CH - 1);

    // One enable per implemented channel.
    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_en
            assign chan_en[g] = (chan == CH_W'(g));
        end
    endgenerate

    // Reserved codes lie above the last implemented channel.
    assign chan_none   = (chan > LAST_CODE);
    // A reserved channel converts as a zero input.
    assign cmp_hit     = cmp_raw & ~chan_none;
    // Shared-pin interrupt is masked while its pin serves as analog input.
    assign ext_irq_out = ext_irq_in & (chan != GATE_CODE);

    AST_GATE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (chan == GATE_CODE) |-> !ext_irq_out); // R10
    AST_RESERVED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        chan_none |-> (!cmp_hit && chan_en == '0)); // R11
endmodule

// File: rtl/sar_engine.sv
// Successive-approximation sequencer: one setup cycle, then RES_W trial
// cycles from the MSB down. Assumes cmp_hit is valid in the same cycle as
// dac_code (combinational comparator path outside the block).
module sar_engine
    import sar_adc_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_hit,
    output logic [RES_W-1:0] dac_code,
    output logic             done,
    output logic [RES_W-1:0] res_final
);
    localparam int IDX_W = $clog2(RES_W);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);

    sar_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] acc;
    logic [RES_W-1:0] trial_bit;

    // Single bit under test in the current trial.
    assign trial_bit = {{(RES_W-1){1'b0}}, 1'b1} << idx;

    // Trial code shown to the DAC only during trials.
    assign dac_code  = (state == ST_TRIAL) ? (acc | trial_bit) : '0;

    // Last trial finishing, unless a restart overrides it.
    assign done      = (state == ST_TRIAL) && (idx == '0) && !start;

    // Result including the decision on the final bit.
    assign res_final = acc | (cmp_hit ? trial_bit : '0);

    // State, bit index and accumulated code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            acc   <= '0;
        end else if (start) begin
            state <= ST_SETUP;
            idx   <= IDX_TOP;
            acc   <= '0;
        end else begin
            case (state)
                ST_SETUP: state <= ST_TRIAL;
                ST_TRIAL: begin
                    acc[idx] <= cmp_hit;
                    if (idx == '0) state <= ST_IDLE;
                    else           idx   <= idx - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_START_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_SETUP && idx == IDX_TOP)); // R8
    AST_SETUP_TO_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP && !start) |=> (state == ST_TRIAL && dac_code[RES_W-1])); // R5
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == ST_IDLE && dac_code == '0)); // R12
    AST_TRIAL_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIAL) |-> (dac_code[idx] && $countones(dac_code & ~(acc | trial_bit)) == 0)); // R5
endmodule

// File: rtl/sar_regs.sv
// Register file: control register (channel, completion flag), split result
// registers, interrupt request. Assumes RES_W > DATA_W and the flag bit
// lies above the channel field.
module sar_regs
    import sar_adc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RES_W  = 10,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [7:0]        bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_clr,
    input  logic              done,
    input  logic [RES_W-1:0]  res_final,
    output logic              start,
    output logic [CH_W-1:0]   chan,
    output logic              irq_req
);
    localparam int LO_W = RES_W - DATA_W;

    logic             flag;
    logic             ctrl_wr;
    logic [RES_W-1:0] result;

    // Control-register write decode and conversion start.
    assign ctrl_wr = bus_wr && (bus_waddr == ADDR_CTRL);
    assign start   = ctrl_wr && !bus_wdata[FLAG_BIT];

    // Channel field follows every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       chan <= '0;
        else if (ctrl_wr) chan <= bus_wdata[CH_W-1:0];
    end

    // Completion flag: cleared by start, set on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b1;
        else if (start) flag <= 1'b0;
        else if (done)  flag <= 1'b1;
    end

    // Result captured only at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)    result <= '0;
        else if (done) result <= res_final;
    end

    // Interrupt request: set wins over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_req <= 1'b0;
        else if (done)    irq_req <= 1'b1;
        else if (irq_clr) irq_req <= 1'b0;
    end

    // Read mux with unused bits returning zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_raddr)
            ADDR_CTRL: begin
                bus_rdata[CH_W-1:0] = chan;
                bus_rdata[FLAG_BIT] = flag;
            end
            ADDR_RES_LO: bus_rdata[DATA_W-1 -: LO_W] = result[LO_W-1:0];
            ADDR_RES_HI: bus_rdata = result[RES_W-1 -: DATA_W];
            default:     bus_rdata = '0;
        endcase
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(result)); // R7
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (irq_req && flag)); // R9
    AST_FLAG_LOW_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !flag); // R3
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_clr) |=> irq_req); // R9
endmodule

// File: rtl/sar_adc_ctl.sv
// Top level of the SAR ADC sequencer: register file, SAR engine and channel
// decode. Assumes a combinational comparator path from dac_code to cmp_in
// settling within one clock.
module sar_adc_ctl #(
    parameter int DATA_W  = 8,
    parameter int RES_W   = 10,
    parameter int CH_W    = 4,
    parameter int NUM_CH  = 12,
    parameter int GATE_CH = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [7:0]        bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_clr,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  dac_code,
    output logic [CH_W-1:0]   chan_sel,
    output logic [NUM_CH-1:0] chan_en,
    output logic              chan_none,
    output logic              irq_req,
    input  logic              ext_irq_in,
    output logic              ext_irq_out
);
    logic             start;
    logic             done;
    logic             cmp_hit;
    logic [RES_W-1:0] res_final;

    sar_regs #(.DATA_W(DATA_W), .RES_W(RES_W), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .irq_clr(irq_clr), .done(done), .res_final(res_final),
        .start(start), .chan(chan_sel), .irq_req(irq_req)
    );

    sar_engine #(.RES_W(RES_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start(start), .cmp_hit(cmp_hit),
        .dac_code(dac_code), .done(done), .res_final(res_final)
    );

    sar_chan_decode #(.CH_W(CH_W), .NUM_CH(NUM_CH), .GATE_CH(GATE_CH)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .chan(chan_sel), .cmp_raw(cmp_in), .ext_irq_in(ext_irq_in),
        .chan_en(chan_en), .chan_none(chan_none),
        .cmp_hit(cmp_hit), .ext_irq_out(ext_irq_out)
    );
endmodule

// File: tb/sim_sar_adc_ctl.sv
`timescale 1ns/100ps
module sim_sar_adc_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_waddr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_raddr = 8'h32;
    logic [7:0]  bus_rdata;
    logic        irq_clr = 1'b0;
    logic        cmp_in;
    logic [9:0]  dac_code;
    logic [3:0]  chan_sel;
    logic [11:0] chan_en;
    logic        chan_none;
    logic        irq_req;
    logic        ext_irq_in = 1'b0;
    logic        ext_irq_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [9:0] ana [16];
    logic [9:0] exp_q [$];
    logic [9:0] last_res = 10'd0;

    always #4 clk = ~clk;

    sar_adc_ctl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .irq_clr(irq_clr), .cmp_in(cmp_in), .dac_code(dac_code),
        .chan_sel(chan_sel), .chan_en(chan_en), .chan_none(chan_none),
        .irq_req(irq_req), .ext_irq_in(ext_irq_in), .ext_irq_out(ext_irq_out)
    );

    // Behavioural comparator: input at or above the trial voltage.
    assign cmp_in = (ana[chan_sel] >= dac_code);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_raddr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = 8'h32; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: pushes the expected result and issues the start write.
    task automatic start_conv(input logic [3:0] ch, input logic [9:0] v);
        ana[ch] = v;
        exp_q.push_back((ch >= 4'd12) ? 10'd0 : v);
        wr_ctrl({4'b0000, ch});
    endtask

    // After start_conv: verifies timing (R4) and releases the request.
    task automatic finish_conv(input string tag);
        logic [7:0] d;
        repeat (10) @(negedge clk);
        #2; rd(8'h32, d);
        check({tag, " R4 flag low before edge 11"}, {15'd0, d[4]}, 16'd0);
        @(negedge clk);
        #2; rd(8'h32, d);
        check({tag, " R4 flag at edge 11"}, {15'd0, d[4]}, 16'd1);
        check({tag, " R4 irq at edge 11"}, {15'd0, irq_req}, 16'd1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        #2;
        check({tag, " R9 irq cleared"}, {15'd0, irq_req}, 16'd0);
    endtask

    // Monitor: pops the expectation on each irq rise and compares results.
    initial begin
        logic irq_q;
        logic [7:0] hi, lo;
        irq_q = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && irq_req && !irq_q) begin
                rd(8'h34, hi);
                rd(8'h33, lo);
                if (exp_q.size() == 0) begin
                    check("R5 unexpected completion", 16'd1, 16'd0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    check("R5 R6 result high", {8'd0, hi}, {8'd0, e[9:2]});
                    check("R6 result low", {8'd0, lo}, {8'd0, e[1:0], 6'd0});
                    last_res = e;
                end
            end
            irq_q = irq_req;
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 16; i++) ana[i] = 10'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        rd(8'h32, d); check("R1 ctrl reset", {8'd0, d}, 16'h0010);
        rd(8'h33, d); check("R1 low reset", {8'd0, d}, 16'h0000);
        rd(8'h34, d); check("R1 high reset", {8'd0, d}, 16'h0000);
        check("R1 irq reset", {15'd0, irq_req}, 16'd0);
        check("R12 dac idle", {6'd0, dac_code}, 16'd0);

        // R3: flag=1 write while idle starts nothing; R2 readback.
        wr_ctrl(8'hF3);
        repeat (13) @(negedge clk);
        #2; rd(8'h32, d);
        check("R2 R3 no start, bits 7:5 zero", {8'd0, d}, 16'h0013);
        check("R3 no irq", {15'd0, irq_req}, 16'd0);

        // Conversion with high bits written; R2/R3/R5/R7/R12 mid-checks.
        ana[3] = 10'h2AA;
        exp_q.push_back(10'h2AA);
        wr_ctrl(8'hE3);
        #2; rd(8'h32, d);
        check("R2 R3 flag low, bits 7:5 zero", {8'd0, d}, 16'h0003);
        check("R12 dac in setup", {6'd0, dac_code}, 16'd0);
        @(negedge clk); #2;
        check("R5 first trial code", {6'd0, dac_code}, 16'h0200);
        repeat (3) @(negedge clk); #2;
        rd(8'h34, d); check("R7 high held", {8'd0, d}, 16'h0000);
        rd(8'h33, d); check("R7 low held", {8'd0, d}, 16'h0000);
        repeat (6) @(negedge clk);
        #2; rd(8'h32, d);
        check("R4 flag low before edge 11", {15'd0, d[4]}, 16'd0);
        @(negedge clk); #2;
        check("R4 irq at edge 11", {15'd0, irq_req}, 16'd1);
        check("R12 dac idle after", {6'd0, dac_code}, 16'd0);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

        // Several patterns through the scoreboard.
        start_conv(4'd0, 10'd1023);  finish_conv("full");
        start_conv(4'd7, 10'd0);     finish_conv("zero");
        start_conv(4'd1, 10'd512);   finish_conv("msb");
        start_conv(4'd11, 10'd511);  finish_conv("below msb");
        start_conv(4'd5, 10'h155);   finish_conv("alt");

        // R7 with a nonzero previous result.
        start_conv(4'd2, 10'd700);
        repeat (5) @(negedge clk); #2;
        rd(8'h34, d); check("R7 high keeps previous", {8'd0, d}, {8'd0, 8'h55});
        rd(8'h33, d); check("R7 low keeps previous", {8'd0, d}, {8'd0, 8'h40});
        repeat (6) @(negedge clk);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

        // R8: restart mid conversion; only the second start is expected.
        ana[4] = 10'd300;
        wr_ctrl(8'h04);
        repeat (5) @(negedge clk);
        start_conv(4'd4, 10'd301);
        finish_conv("R8 restart");

        // R9: clear and completion on the same edge.
        start_conv(4'd6, 10'd77);
        repeat (10) @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        #2;
        check("R9 set wins over clear", {15'd0, irq_req}, 16'd1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; #2;
        check("R9 later clear", {15'd0, irq_req}, 16'd0);

        // R10: interrupt gating on the shared channel.
        ext_irq_in = 1'b1;
        wr_ctrl(8'h1A); #2;
        check("R10 masked on 1010", {15'd0, ext_irq_out}, 16'd0);
        wr_ctrl(8'h19); #2;
        check("R10 passes on 1001", {15'd0, ext_irq_out}, 16'd1);
        ext_irq_in = 1'b0;

        // R11: reserved channel converts as zero.
        start_conv(4'd12, 10'd800);
        #2;
        check("R11 chan_none", {15'd0, chan_none}, 16'd1);
        check("R11 no enable", {4'd0, chan_en}, 16'd0);
        rd(8'h32, d); check("R11 code stored", {8'd0, d}, 16'h000C);
        finish_conv("R11 reserved");
        wr_ctrl(8'h1F); #2;
        check("R11 code 1111", {15'd0, chan_none}, 16'd1);

        repeat (3) @(negedge clk);
        check("R5 scoreboard drained", exp_q.size() == 0 ? 16'd0 : 16'd1, 16'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule